// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block is the fetch-stage field extractor of a small 32-bit teaching processor whose instructions are 1, 2, 5 or 6 bytes long. Instruction memory hands it a six-byte window that begins at the current program counter. From that window the block pulls out the opcode and function nibbles, the optional register-specifier byte and the optional four-byte constant. It also produces the address of the next sequential instruction and a flag that marks undefined opcodes.

The opcode alone decides the layout. It sets whether a register byte follows the opcode, whether a constant word is present, and where that constant begins: byte 2 when a register byte comes before it, byte 1 when it does not. The block is purely combinational. Its outputs follow the window and the program counter within the same cycle, with no state of its own. The PC register, instruction memory and decode-stage register selection sit around it.

Top module: `fetch_aligner`

## Requirements
- R1: Window byte k is `win_i[8k+7:8k]`, and byte 0 sits at the program counter. `icode_o` is byte 0 bits [7:4] and `ifun_o` is byte 0 bits [3:0]. This holds for every opcode, including undefined ones.
- R2: For opcode codes 2, 3, 4, 5, 6, A and B, `ra_o` is byte 1 bits [7:4] and `rb_o` is byte 1 bits [3:0]. Both are passed through unchanged, including the value 8.
- R3: For every other opcode code (0, 1, 7, 8, 9 and the undefined codes C to F), `ra_o` and `rb_o` are both 8, which means "no register".
- R4: For codes 3, 4 and 5, `valc_o` is bytes 2 to 5 read little-endian: byte 2 is the least significant byte and byte 5 the most significant.
- R5: For codes 7 and 8, `valc_o` is bytes 1 to 4 read little-endian: byte 1 is the least significant byte.
- R6: For all other codes, `valc_o` is zero.
- R7: `valp_o` is `pc_i` plus the instruction length. The length is 6 for codes 3, 4 and 5; 5 for codes 7 and 8; 2 for codes 2, 6, A and B; and 1 for codes 0, 1, 9 and every undefined code.
- R8: `instr_valid_o` is 1 exactly when the opcode code is in the range 0 to B.
- R9: The `valp_o` addition wraps modulo 2^32 when an instruction ends past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| win_i | input | 48 | Six instruction bytes starting at the PC; byte k at bits [8k+7:8k] |
| pc_i | input | 32 | Address of byte 0 of the window |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier, or 8 if absent |
| rb_o | output | 4 | Second register specifier, or 8 if absent |
| valc_o | output | 32 | Constant word, or zero if absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| instr_valid_o | output | 1 | High when the opcode is defined |

## Verification
There is no stored state, so any fault in the opcode classification shows at the ports in the same cycle the window is applied. A wrong length class shows first as an odd `valp_o` step. A wrong register-byte decision shows as specifiers that are 8 when they should be real, or real when they should be 8. A wrong constant offset shows as `valc_o` shifted by one byte. The checks apply every opcode with distinctive filler bytes, so that any read from the wrong byte position changes a field value.

// File: rtl/fetch_align_pkg.sv
// Package: shared opcode codes and the per-opcode format record used by the
// fetch aligner. Assumes four-bit opcode and register nibbles.
package fetch_align_pkg;

    localparam int NIB_W   = 4;
    localparam int LEN_W   = 3;
    localparam logic [NIB_W-1:0] REG_NONE = 4'h8;

    typedef enum logic [NIB_W-1:0] {
        OP_NOP     = 4'h0,
        OP_HALT    = 4'h1,
        OP_MOV_RR  = 4'h2,
        OP_MOV_IR  = 4'h3,
        OP_STORE   = 4'h4,
        OP_LOAD    = 4'h5,
        OP_ALU     = 4'h6,
        OP_BRANCH  = 4'h7,
        OP_CALL    = 4'h8,
        OP_RET     = 4'h9,
        OP_PUSH    = 4'hA,
        OP_POP     = 4'hB
    } op_e;

    typedef struct packed {
        logic             has_regs;
        logic             has_const;
        logic             defined;
        logic [LEN_W-1:0] len;
    } fmt_t;

endpackage

// File: rtl/fa_opcode_split.sv
// Module: fa_opcode_split
// Splits the opcode byte into its two nibbles and classifies the opcode:
// register byte present, constant word present, defined, and byte length.
// Assumes an 8-bit opcode byte with the opcode in the upper nibble.
module fa_opcode_split
    import fetch_align_pkg::*;
(
    input  logic [2*NIB_W-1:0] op_byte_i,
    output logic [NIB_W-1:0]   icode_o,
    output logic [NIB_W-1:0]   ifun_o,
    output fmt_t               fmt_o
);

    // Nibble split of the opcode byte.
    assign icode_o = op_byte_i[2*NIB_W-1:NIB_W];
    assign ifun_o  = op_byte_i[NIB_W-1:0];

    // Format lookup per opcode; undefined codes fall to a one-byte no-field form.
    always_comb begin
        fmt_o = '{has_regs: 1'b0, has_const: 1'b0, defined: 1'b0, len: 3'd1};
        case (icode_o)
            OP_NOP, OP_HALT, OP_RET:
                fmt_o = '{has_regs: 1'b0, has_const: 1'b0, defined: 1'b1, len: 3'd1};
            OP_MOV_RR, OP_ALU, OP_PUSH, OP_POP:
                fmt_o = '{has_regs: 1'b1, has_const: 1'b0, defined: 1'b1, len: 3'd2};
            OP_MOV_IR, OP_STORE, OP_LOAD:
                fmt_o = '{has_regs: 1'b1, has_const: 1'b1, defined: 1'b1, len: 3'd6};
            OP_BRANCH, OP_CALL:
                fmt_o = '{has_regs: 1'b0, has_const: 1'b1, defined: 1'b1, len: 3'd5};
            default:
                fmt_o = '{has_regs: 1'b0, has_const: 1'b0, defined: 1'b0, len: 3'd1};
        endcase
    end

endmodule

// File: rtl/fa_field_align.sv
// Module: fa_field_align
// Takes the window bytes after the opcode byte and aligns the register
// specifiers and the little-endian constant word. The constant starts right
// after the register byte when one is present, otherwise right after the opcode.
// Assumes the window holds at least two plus the constant's byte count bytes.
module fa_field_align
    import fetch_align_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int WIN_BYTES = 6
) (
    input  logic [(WIN_BYTES-1)*BYTE_W-1:0] tail_i,
    input  logic                            has_regs_i,
    input  logic                            has_const_i,
    output logic [NIB_W-1:0]                ra_o,
    output logic [NIB_W-1:0]                rb_o,
    output logic [WORD_W-1:0]               valc_o
);

    localparam int CONST_BYTES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] const_after_reg;
    logic [WORD_W-1:0] const_after_op;

    // Byte lanes of both candidate constants; tail byte j is window byte j+1.
    for (genvar k = 0; k < CONST_BYTES; k++) begin : g_lane
        assign const_after_op[k*BYTE_W +: BYTE_W]  = tail_i[k*BYTE_W +: BYTE_W];
        assign const_after_reg[k*BYTE_W +: BYTE_W] = tail_i[(k+1)*BYTE_W +: BYTE_W];
    end

    // Register specifiers from the first tail byte, or the no-register code.
    always_comb begin
        if (has_regs_i) begin
            ra_o = tail_i[BYTE_W-1:NIB_W];
            rb_o = tail_i[NIB_W-1:0];
        end else begin
            ra_o = REG_NONE;
            rb_o = REG_NONE;
        end
    end

    // Constant selection by offset, zero when absent.
    always_comb begin
        if (!has_const_i)     valc_o = '0;
        else if (has_regs_i)  valc_o = const_after_reg;
        else                  valc_o = const_after_op;
    end

endmodule

// File: rtl/fa_next_pc.sv
// Module: fa_next_pc
// Adds the instruction length to the program counter, wrapping modulo 2^WORD_W.
// Assumes the length fits in LEN_W bits.
module fa_next_pc
    import fetch_align_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [WORD_W-1:0] valp_o
);

    // Sequential successor address.
    assign valp_o = pc_i + {{(WORD_W-LEN_W){1'b0}}, len_i};

endmodule

// File: rtl/fetch_aligner.sv
// Module: fetch_aligner (top)
// Fetch-stage aligner for a variable-length instruction set: classifies the
// opcode, extracts register specifiers and constant, and forms the next PC.
// Purely combinational. Assumes the window starts at pc_i, byte 0 at the LSBs.
module fetch_aligner
    import fetch_align_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int WIN_BYTES = 6
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    input  logic [WORD_W-1:0]           pc_i,
    output logic [NIB_W-1:0]            icode_o,
    output logic [NIB_W-1:0]            ifun_o,
    output logic [NIB_W-1:0]            ra_o,
    output logic [NIB_W-1:0]            rb_o,
    output logic [WORD_W-1:0]           valc_o,
    output logic [WORD_W-1:0]           valp_o,
    output logic                        instr_valid_o
);

    localparam int WIN_W = WIN_BYTES * BYTE_W;

    fmt_t fmt;

    fa_opcode_split u_split (
        .op_byte_i (win_i[BYTE_W-1:0]),
        .icode_o   (icode_o),
        .ifun_o    (ifun_o),
        .fmt_o     (fmt)
    );

    fa_field_align #(
        .WORD_W    (WORD_W),
        .BYTE_W    (BYTE_W),
        .WIN_BYTES (WIN_BYTES)
    ) u_fields (
        .tail_i      (win_i[WIN_W-1:BYTE_W]),
        .has_regs_i  (fmt.has_regs),
        .has_const_i (fmt.has_const),
        .ra_o        (ra_o),
        .rb_o        (rb_o),
        .valc_o      (valc_o)
    );

    fa_next_pc #(
        .WORD_W (WORD_W)
    ) u_npc (
        .pc_i   (pc_i),
        .len_i  (fmt.len),
        .valp_o (valp_o)
    );

    // Definedness flag straight from the classifier.
    assign instr_valid_o = fmt.defined;

endmodule

// File: rtl/fetch_aligner_chk.sv
// Module: fetch_aligner_chk
// Port-level consistency checks for fetch_aligner, attached by bind below.
// Uses immediate assertions since the block has no clock.
module fetch_aligner_chk
    import fetch_align_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input logic [BYTE_W-1:0] op_byte,
    input logic [WORD_W-1:0] pc,
    input logic [NIB_W-1:0]  icode,
    input logic [NIB_W-1:0]  ifun,
    input logic [NIB_W-1:0]  ra,
    input logic [NIB_W-1:0]  rb,
    input logic [WORD_W-1:0] valc,
    input logic [WORD_W-1:0] valp,
    input logic              valid
);

    logic [WORD_W-1:0] step;
    assign step = valp - pc;

    // Output relations that must hold for any window.
    always_comb begin
        p_split_r1: assert ({icode, ifun} == op_byte);
        p_step_r7: assert (step == 1 || step == 2 || step == 5 || step == 6);
        p_noreg_r3: assert (!(step == 1 || step == 5) || (ra == REG_NONE && rb == REG_NONE));
        p_noconst_r6: assert (!(step == 1 || step == 2) || valc == '0);
        p_defined_r8: assert (valid == (icode <= 4'hB));
        p_undef_r8: assert (valid || (step == 1 && ra == REG_NONE && rb == REG_NONE && valc == '0));
    end

endmodule

bind fetch_aligner fetch_aligner_chk #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .op_byte (win_i[BYTE_W-1:0]),
    .pc      (pc_i),
    .icode   (icode_o),
    .ifun    (ifun_o),
    .ra      (ra_o),
    .rb      (rb_o),
    .valc    (valc_o),
    .valp    (valp_o),
    .valid   (instr_valid_o)
);

// File: tb/fetch_aligner_bench.sv
// Bench for fetch_aligner: a vector table walked by one loop, then directed cases.
module fetch_aligner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] win;
    logic [31:0] pc;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp;
    logic        valid;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fetch_aligner u_fetch_aligner (
        .win_i (win), .pc_i (pc), .icode_o (icode), .ifun_o (ifun),
        .ra_o (ra), .rb_o (rb), .valc_o (valc), .valp_o (valp),
        .instr_valid_o (valid)
    );

    typedef struct packed {
        logic [47:0] w;
        logic [31:0] p;
        logic [31:0] ep;
        logic [31:0] ec;
        logic [3:0]  ea;
        logic [3:0]  eb;
        logic        ev;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{48'hA5A5A5A5A500, 32'h00000100, 32'h00000101, 32'h0,        4'h8, 4'h8, 1'b1},
        '{48'h123456789A10, 32'h00000200, 32'h00000201, 32'h0,        4'h8, 4'h8, 1'b1},
        '{48'hDEADBEEF3120, 32'h00000010, 32'h00000012, 32'h0,        4'h3, 4'h1, 1'b1},
        '{48'h123456788230, 32'h00000020, 32'h00000026, 32'h12345678, 4'h8, 4'h2, 1'b1},
        '{48'h010203046740, 32'h00001000, 32'h00001006, 32'h01020304, 4'h6, 4'h7, 1'b1},
        '{48'hDEADBEEF4550, 32'h00000030, 32'h00000036, 32'hDEADBEEF, 4'h4, 4'h5, 1'b1},
        '{48'hFFFFFFFF0361, 32'h00000040, 32'h00000042, 32'h0,        4'h0, 4'h3, 1'b1},
        '{48'hCC0000100071, 32'h00000050, 32'h00000055, 32'h00001000, 4'h8, 4'h8, 1'b1},
        '{48'h9A1234567880, 32'h00000060, 32'h00000065, 32'h12345678, 4'h8, 4'h8, 1'b1},
        '{48'h111111111190, 32'h00000070, 32'h00000071, 32'h0,        4'h8, 4'h8, 1'b1},
        '{48'h0000000048A0, 32'h00000080, 32'h00000082, 32'h0,        4'h4, 4'h8, 1'b1},
        '{48'h0000000058B0, 32'h00000090, 32'h00000092, 32'h0,        4'h5, 4'h8, 1'b1},
        '{48'h1234567855C0, 32'h000000A0, 32'h000000A1, 32'h0,        4'h8, 4'h8, 1'b0},
        '{48'hFFFFFFFFFFF3, 32'h00000000, 32'h00000001, 32'h0,        4'h8, 4'h8, 1'b0},
        '{48'h000000011030, 32'hFFFFFFFC, 32'h00000002, 32'h00000001, 4'h1, 4'h0, 1'b1},
        '{48'h00FFFFFFFF70, 32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFF, 4'h8, 4'h8, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one window and check every output against the expected values.
    task automatic run_vec(input vec_t v);
        logic [3:0] op;
        @(posedge clk);
        win = v.w;
        pc  = v.p;
        @(negedge clk);
        op = v.w[7:4];
        chk("R1", "icode", {28'h0, icode}, {28'h0, v.w[7:4]});
        chk("R1", "ifun", {28'h0, ifun}, {28'h0, v.w[3:0]});
        if (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB}) begin
            chk("R2", "rA", {28'h0, ra}, {28'h0, v.ea});
            chk("R2", "rB", {28'h0, rb}, {28'h0, v.eb});
        end else begin
            chk("R3", "rA", {28'h0, ra}, {28'h0, v.ea});
            chk("R3", "rB", {28'h0, rb}, {28'h0, v.eb});
        end
        if (op inside {4'h3, 4'h4, 4'h5})      chk("R4", "valC", valc, v.ec);
        else if (op inside {4'h7, 4'h8})       chk("R5", "valC", valc, v.ec);
        else                                   chk("R6", "valC", valc, v.ec);
        if (v.ep < v.p) chk("R9", "valP", valp, v.ep);
        else            chk("R7", "valP", valp, v.ep);
        chk("R8", "valid", {31'h0, valid}, {31'h0, v.ev});
    endtask

    initial begin
        win = '0;
        pc  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: all-zero window decodes as a one-byte nop.
        chk("R7", "reset valP", valp, 32'h1);
        chk("R3", "reset rA", {28'h0, ra}, 32'h8);
        chk("R8", "reset valid", {31'h0, valid}, 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // Directed: popl with rB other than 8 passes through (R2).
        run_vec('{48'h999999994FB0, 32'h00000400, 32'h00000402, 32'h0, 4'h4, 4'hF, 1'b1});
        // Directed: undefined code D with busy bytes gives no fields (R3, R6, R8).
        run_vec('{48'hFFEEDDCCBBD7, 32'h00000500, 32'h00000501, 32'h0, 4'h8, 4'h8, 1'b0});
        // Directed: call at the last address wraps valP (R9).
        run_vec('{48'h00AABBCCDD80, 32'hFFFFFFFF, 32'h00000004, 32'hAABBCCDD, 4'h8, 4'h8, 1'b1});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule